// File: doc/BRIEF.md
# Burst-Four Late-Write DDR SRAM Core

This block models the memory side of a synchronous static RAM with a common data bus and double-data-rate transfers. Every access moves a fixed burst of four words. Commands and the block address are taken only at the main clock edge of each memory cycle, called the K edge. Write data and byte enables arrive on both the K edge and the complementary K# edge. The block uses one clock, `clk`, which runs at twice the memory-cycle rate. An internal phase flag marks each `clk` rising edge as either a K edge or a K# edge, and the output `k_next` shows which kind the coming edge is.

A write command is followed by its four data beats. The first beat comes one memory cycle later. The beats are held in a late-write buffer, and the buffer is written into the array only when the next write starts delivering data. A read is coherent on a per-byte basis: any byte that the buffer holds is passed straight to the read result instead of the value stored in the array. Read beats start on a K# edge, one and a half memory cycles after the command. While they are driven, an output-enable strobe is raised, so the pad ring can turn the shared bus around.

Top module: `ddrb4_sram`

## Requirements
- R1: After reset `k_next` is high, and it toggles on every `clk` cycle. A rising edge of `clk` that `k_next` announces as high is a K edge. Every other rising edge is a K# edge.
- R2: While `rst_n` is low, and afterwards until a read is accepted, `dq_oe` stays low.
- R3: `rd_req` and `wr_req` are sampled only at K edges. A request that is present only at a K# edge changes neither the array nor the bus.
- R4: After a command is accepted, requests at the next K edge are ignored. If `rd_req` and `wr_req` are both high at an accepted edge, only the read is performed, and the array is left unchanged.
- R5: Take the K edge that accepts a write as edge 0. The data beats are sampled from `dq_in` at edges 2, 3, 4 and 5 (K, K#, K, K#). Beat i is written to word `addr*4 + i`.
- R6: Bit `bw[j]` is sampled with each beat. When it is high, that beat's byte `dq_in[LANE_W*j +: LANE_W]` is written. When it is low, that byte keeps its old contents.
- R7: Take the K edge that accepts a read as edge 0. Beat i, which is word `addr*4 + i`, appears on `dq_out` in the `clk` cycle after edge 3+i, and `dq_oe` is high in exactly those four cycles. The first of them follows a K# edge.
- R8: Commands accepted four `clk` edges apart stream without a gap. Two such reads hold `dq_oe` high for eight cycles in a row. Two such writes both land in full.
- R9: A read returns the newest value of every byte, including bytes that are still in the late-write buffer. The buffer is written into the array at the first data beat of the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the memory-cycle rate |
| rst_n | input | 1 | Synchronous active-low reset |
| k_next | output | 1 | High when the coming `clk` edge is a K edge |
| rd_req | input | 1 | Read request, sampled at K edges |
| wr_req | input | 1 | Write request, sampled at K edges |
| addr | input | AW | Burst (four-word block) address, sampled with the request |
| dq_in | input | DW | Write data beat, from the shared bus |
| bw | input | NB | Per-byte write enables for the beat on `dq_in` |
| dq_out | output | DW | Read data beat, toward the shared bus |
| dq_oe | output | 1 | Drive enable for the shared bus, high while read beats are valid |

## Verification
Every block is first written and read back in a full sweep. This shows whether the four beats are mapped to the four words in ascending order. A sweep over every byte-enable value, with the value rotated per beat, separates per-lane masking from whole-word writes. Reads issued straight after a write, including a write with a mixed mask over older data, show whether the result comes from the buffer byte by byte or from a stale array. Requests placed at K# edges, at blocked K edges and together with a read at the same edge must leave both the bus and the array untouched. Back-to-back reads and writes test whether the beat pipelines hand over without a gap.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;
   localparam int BEATS  = 4;
   localparam int BEAT_W = 2;

   // kind of the coming clk edge
   typedef enum logic {
      EDGE_K  = 1'b0,
      EDGE_KB = 1'b1
   } edge_e;
endpackage

// File: rtl/ddrb4_seq.sv
module ddrb4_seq
   import ddrb4_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic [AW-1:0]     addr,
   output logic              k_next,
   output logic              wr_cap,
   output logic              wr_first,
   output logic [BEAT_W-1:0] wr_beat,
   output logic [AW-1:0]     wr_base,
   output logic              lk_vld,
   output logic [AW-1:0]     lk_addr,
   output logic [BEAT_W-1:0] lk_beat
);
   localparam int WDLY = 2;   // K edge to first write beat
   localparam int RDLY = 3;   // K edge to first read beat

   edge_e             ph;
   logic              blk;
   logic [WDLY-1:0]   wdly;
   logic [RDLY-1:0]   rdly;
   logic [AW-1:0]     wp_addr, rp_addr, o_addr;
   logic              wfill, orun;
   logic [BEAT_W-1:0] wcnt, ocnt;
   logic              kedge, rd_acc, wr_acc;

   assign kedge  = (ph == EDGE_K);
   assign k_next = kedge;
   // R3: sample only at K edges; R4: blocked edge, read has priority
   assign rd_acc = kedge && !blk && rd_req;
   assign wr_acc = kedge && !blk && wr_req && !rd_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph      <= EDGE_K;   // R1: first edge after reset is a K edge
         blk     <= 1'b0;
         wdly    <= '0;
         rdly    <= '0;
         wp_addr <= '0;
         rp_addr <= '0;
         o_addr  <= '0;
         wfill   <= 1'b0;
         wcnt    <= '0;
         orun    <= 1'b0;
         ocnt    <= '0;
      end else begin
         ph   <= kedge ? EDGE_KB : EDGE_K;
         if (kedge) blk <= rd_acc || wr_acc;
         wdly <= {wdly[WDLY-2:0], wr_acc};
         rdly <= {rdly[RDLY-2:0], rd_acc};
         if (rd_acc) rp_addr <= addr;
         if (wr_acc) wp_addr <= addr;
         // write beats 1..3 after the first one
         if (wdly[WDLY-1]) begin
            wfill <= 1'b1;
            wcnt  <= BEAT_W'(1);
         end else if (wfill) begin
            wcnt <= wcnt + BEAT_W'(1);
            if (wcnt == BEAT_W'(BEATS-1)) wfill <= 1'b0;
         end
         // read beats 1..3 after the first one
         if (rdly[RDLY-1]) begin
            orun   <= 1'b1;
            ocnt   <= BEAT_W'(1);
            o_addr <= rp_addr;
         end else if (orun) begin
            ocnt <= ocnt + BEAT_W'(1);
            if (ocnt == BEAT_W'(BEATS-1)) orun <= 1'b0;
         end
      end
   end

   assign wr_first = wdly[WDLY-1];
   assign wr_cap   = wdly[WDLY-1] || wfill;
   assign wr_beat  = wdly[WDLY-1] ? '0 : wcnt;
   assign wr_base  = wp_addr;
   assign lk_vld   = rdly[RDLY-1] || orun;
   assign lk_addr  = rdly[RDLY-1] ? rp_addr : o_addr;
   assign lk_beat  = rdly[RDLY-1] ? '0 : ocnt;

   // R4: an accepted command blocks the following K edge
   a_r4_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc || wr_acc) |=> !(rd_acc || wr_acc) ##1 !(rd_acc || wr_acc));
endmodule

// File: rtl/ddrb4_wbuf.sv
module ddrb4_wbuf
   import ddrb4_pkg::*;
#(
   parameter int AW     = 6,
   parameter int DW     = 32,
   parameter int LANE_W = 8,
   localparam int NB    = DW / LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic                first,
   input  logic [BEAT_W-1:0]   beat,
   input  logic [AW-1:0]       base,
   input  logic [DW-1:0]       din,
   input  logic [NB-1:0]       bw,
   input  logic [AW-1:0]       lk_addr,
   input  logic [BEAT_W-1:0]   lk_beat,
   input  logic [DW-1:0]       arr_word,
   output logic [DW-1:0]       fwd_word,
   output logic                cm_en,
   output logic [AW-1:0]       cm_addr,
   output logic [BEATS*DW-1:0] cm_data,
   output logic [BEATS*NB-1:0] cm_mask
);
   logic          bval;
   logic [AW-1:0] baddr;
   logic          hit;
   logic [NB-1:0] sel_mask;
   logic [DW-1:0] sel_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bval  <= 1'b0;
         baddr <= '0;
      end else if (cap && first) begin
         bval  <= 1'b1;
         baddr <= base;
      end
   end

   for (genvar b = 0; b < BEATS; b++) begin : g_slot
      logic [DW-1:0] s_data;
      logic [NB-1:0] s_mask;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            s_data <= '0;
            s_mask <= '0;
         end else if (cap) begin
            if (beat == BEAT_W'(b)) begin
               s_data <= din;
               s_mask <= bw;     // R6: per-beat byte enables
            end else if (first) begin
               s_mask <= '0;
            end
         end
      end
      assign cm_data[b*DW +: DW] = s_data;
      assign cm_mask[b*NB +: NB] = s_mask;
   end

   // R9: previous write retires when the next one delivers its first beat
   assign cm_en   = cap && first && bval;
   assign cm_addr = baddr;

   assign hit      = bval && (baddr == lk_addr);
   assign sel_mask = cm_mask[lk_beat*NB +: NB];
   assign sel_data = cm_data[lk_beat*DW +: DW];

   for (genvar y = 0; y < NB; y++) begin : g_fwd
      assign fwd_word[y*LANE_W +: LANE_W] = (hit && sel_mask[y]) ?
         sel_data[y*LANE_W +: LANE_W] : arr_word[y*LANE_W +: LANE_W];
   end

   // R5: write beats follow one another on consecutive edges
   a_r5_contig: assert property (@(posedge clk) disable iff (!rst_n)
      (cap && !first) |-> $past(cap));
endmodule

// File: rtl/ddrb4_array.sv
module ddrb4_array
   import ddrb4_pkg::*;
#(
   parameter int AW     = 6,
   parameter int DW     = 32,
   parameter int LANE_W = 8,
   localparam int NB    = DW / LANE_W,
   localparam int WORDS = (1 << AW) * BEATS,
   localparam int IW    = AW + BEAT_W
) (
   input  logic                clk,
   input  logic                cm_en,
   input  logic [AW-1:0]       cm_addr,
   input  logic [BEATS*DW-1:0] cm_data,
   input  logic [BEATS*NB-1:0] cm_mask,
   input  logic [AW-1:0]       rd_addr,
   input  logic [BEAT_W-1:0]   rd_beat,
   output logic [DW-1:0]       rd_word
);
   logic [IW-1:0] rd_idx;
   assign rd_idx = {rd_addr, rd_beat};

   for (genvar y = 0; y < NB; y++) begin : g_lane
      logic [LANE_W-1:0] lane [WORDS];
      always_ff @(posedge clk) begin
         if (cm_en) begin
            for (int b = 0; b < BEATS; b++) begin
               if (cm_mask[b*NB + y])
                  lane[{cm_addr, BEAT_W'(b)}] <= cm_data[b*DW + y*LANE_W +: LANE_W];
            end
         end
      end
      assign rd_word[y*LANE_W +: LANE_W] = lane[rd_idx];
   end
endmodule

// File: rtl/ddrb4_sram.sv
module ddrb4_sram
   import ddrb4_pkg::*;
#(
   parameter int DW     = 32,
   parameter int LANE_W = 8,
   parameter int BLOCKS = 64,
   localparam int NB    = DW / LANE_W,
   localparam int AW    = $clog2(BLOCKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          k_next,
   input  logic          rd_req,
   input  logic          wr_req,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] dq_in,
   input  logic [NB-1:0] bw,
   output logic [DW-1:0] dq_out,
   output logic          dq_oe
);
   initial begin
      assert (DW % LANE_W == 0) else $fatal(1, "DW must be a multiple of LANE_W");
      assert (BLOCKS >= 2 && (BLOCKS & (BLOCKS - 1)) == 0)
         else $fatal(1, "BLOCKS must be a power of two");
   end

   logic                wr_cap, wr_first, lk_vld, cm_en;
   logic [BEAT_W-1:0]   wr_beat, lk_beat;
   logic [AW-1:0]       wr_base, lk_addr, cm_addr;
   logic [DW-1:0]       arr_word, fwd_word;
   logic [BEATS*DW-1:0] cm_data;
   logic [BEATS*NB-1:0] cm_mask;

   ddrb4_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req), .addr(addr),
      .k_next(k_next), .wr_cap(wr_cap), .wr_first(wr_first), .wr_beat(wr_beat),
      .wr_base(wr_base), .lk_vld(lk_vld), .lk_addr(lk_addr), .lk_beat(lk_beat)
   );

   ddrb4_wbuf #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .cap(wr_cap), .first(wr_first), .beat(wr_beat),
      .base(wr_base), .din(dq_in), .bw(bw), .lk_addr(lk_addr), .lk_beat(lk_beat),
      .arr_word(arr_word), .fwd_word(fwd_word), .cm_en(cm_en), .cm_addr(cm_addr),
      .cm_data(cm_data), .cm_mask(cm_mask)
   );

   ddrb4_array #(.AW(AW), .DW(DW), .LANE_W(LANE_W)) u_array (
      .clk(clk), .cm_en(cm_en), .cm_addr(cm_addr), .cm_data(cm_data),
      .cm_mask(cm_mask), .rd_addr(lk_addr), .rd_beat(lk_beat), .rd_word(arr_word)
   );

   // read output register; R2: bus released in reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dq_out <= '0;
         dq_oe  <= 1'b0;
      end else begin
         dq_oe <= lk_vld;
         if (lk_vld) dq_out <= fwd_word;
      end
   end

   // R7: a read burst drives at least four beats
   a_r7_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |=> dq_oe ##1 dq_oe ##1 dq_oe);

   // R7: the first read beat follows a K# edge
   a_r7_kbar_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe) |-> k_next);
endmodule

// File: tb/sim_ddrb4_sram.sv
module sim_ddrb4_sram;
   localparam int DW = 16, LW = 8, NB = 2, BLOCKS = 8, AW = 3;
   localparam int WORDS = BLOCKS * 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          k_next;
   logic          rd_req = 1'b0, wr_req = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [NB-1:0] bw = '0;
   logic [DW-1:0] dq_out;
   logic          dq_oe;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [WORDS];

   always #4 clk = ~clk;   // 125 MHz

   ddrb4_sram #(.DW(DW), .LANE_W(LW), .BLOCKS(BLOCKS)) u0 (
      .clk(clk), .rst_n(rst_n), .k_next(k_next), .rd_req(rd_req), .wr_req(wr_req),
      .addr(addr), .dq_in(dq_in), .bw(bw), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual=hung expected=completion");
         summary();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int a, input int b, input int s);
      return DW'(a * 1237 + b * 379 + s * 4099 + 'h1b5);
   endfunction

   task automatic put_beat(input int a, input int b, input int s, input logic [NB-1:0] m);
      dq_in = pat(a, b, s);
      bw    = m;
      for (int y = 0; y < NB; y++)
         if (m[y]) model[a*4+b][y*LW +: LW] = dq_in[y*LW +: LW];
   endtask

   // write burst; caller sits at a negedge
   task automatic do_wr(input int a, input int s, input logic [4*NB-1:0] m);
      if (!k_next) @(negedge clk);
      wr_req = 1'b1; addr = AW'(a);
      @(negedge clk); wr_req = 1'b0;
      @(negedge clk);
      for (int b = 0; b < 4; b++) begin
         put_beat(a, b, s, m[b*NB +: NB]);
         @(negedge clk);
      end
      bw = '0; dq_in = '0;
   endtask

   // read burst with beat-by-beat checks (R7, plus the caller's tag)
   task automatic do_rd(input int a, input string tag);
      if (!k_next) @(negedge clk);
      rd_req = 1'b1; addr = AW'(a);
      @(negedge clk); rd_req = 1'b0;
      for (int k = 1; k <= 8; k++) begin
         if (k >= 4 && k <= 7) begin
            chk("R7 dq_oe during beat", DW'(dq_oe), DW'(1));
            chk(tag, dq_out, model[a*4 + k - 4]);
         end else begin
            chk("R7 dq_oe outside burst", DW'(dq_oe), DW'(0));
         end
         if (k < 8) @(negedge clk);
      end
   endtask

   initial begin
      logic [DW-1:0] old [4];
      repeat (3) @(negedge clk);
      chk("R2 dq_oe in reset", DW'(dq_oe), DW'(0));
      rst_n = 1'b1;
      chk("R1 k_next after reset", DW'(k_next), DW'(1));
      chk("R2 dq_oe after reset", DW'(dq_oe), DW'(0));
      @(negedge clk);
      chk("R1 k_next toggles low", DW'(k_next), DW'(0));
      @(negedge clk);
      chk("R1 k_next toggles high", DW'(k_next), DW'(1));

      // R5: full sweep of every block, beats to words in order
      for (int a = 0; a < BLOCKS; a++) do_wr(a, 10, '1);
      do_wr(0, 10, '1);   // retires the buffer of the last block
      for (int a = 0; a < BLOCKS; a++) do_rd(a, "R5 sweep readback");

      // R6: every byte-enable value, rotated across beats
      for (int m = 0; m < (1 << NB); m++) begin
         logic [4*NB-1:0] mm;
         for (int b = 0; b < 4; b++) mm[b*NB +: NB] = NB'((m + b) % (1 << NB));
         do_wr(3, 20 + m, mm);
         do_rd(3, "R6 mask sweep");
      end

      // R9: forwarding from the buffer, whole words and mixed bytes
      do_wr(5, 40, '1);
      do_rd(5, "R9 read hits buffer");
      do_wr(6, 41, '1);
      do_wr(6, 42, 8'b01_10_11_00);
      do_rd(6, "R9 per-byte forward");
      do_wr(1, 43, '1);
      do_rd(6, "R9 after retire");

      // R3: request present only at a K# edge
      if (!k_next) @(negedge clk);
      @(negedge clk);
      wr_req = 1'b1; addr = AW'(2);
      @(negedge clk); wr_req = 1'b0;
      for (int k = 0; k < 6; k++) begin
         dq_in = 16'hdead; bw = '1; @(negedge clk);
      end
      bw = '0;
      do_wr(0, 44, '1);   // retires any buffered data
      do_rd(2, "R3 K# write ignored");
      if (!k_next) @(negedge clk);
      @(negedge clk);
      rd_req = 1'b1; addr = AW'(4);
      @(negedge clk); rd_req = 1'b0;
      for (int k = 0; k < 8; k++) begin
         chk("R3 K# read ignored", DW'(dq_oe), DW'(0));
         @(negedge clk);
      end

      // R4: write at the blocked K edge is dropped
      if (!k_next) @(negedge clk);
      wr_req = 1'b1; addr = AW'(1);
      for (int k = 1; k <= 6; k++) begin
         @(negedge clk);
         wr_req = (k == 2);
         if (k == 2) addr = AW'(7);
         if (k >= 2 && k <= 5) put_beat(1, k - 2, 45, '1);
      end
      bw = '0;
      do_wr(0, 46, '1);
      do_rd(7, "R4 blocked write ignored");
      do_rd(1, "R4 accepted write landed");

      // R4: blocked read gives only one burst
      if (!k_next) @(negedge clk);
      rd_req = 1'b1; addr = AW'(2);
      for (int k = 1; k <= 11; k++) begin
         @(negedge clk);
         rd_req = (k == 2);
         if (k == 2) addr = AW'(4);
         if (k >= 4 && k <= 7) chk("R4 first read beats", dq_out, model[8 + k - 4]);
         if (k >= 8) chk("R4 blocked read no beats", DW'(dq_oe), DW'(0));
      end
      rd_req = 1'b0;

      // R4: read wins over write at the same edge
      for (int b = 0; b < 4; b++) old[b] = model[4*4 + b];
      if (!k_next) @(negedge clk);
      rd_req = 1'b1; wr_req = 1'b1; addr = AW'(4);
      for (int k = 1; k <= 8; k++) begin
         @(negedge clk);
         rd_req = 1'b0; wr_req = 1'b0;
         dq_in = 16'hbeef; bw = '1;
         if (k >= 4 && k <= 7) chk("R4 read priority data", dq_out, old[k - 4]);
      end
      bw = '0;
      do_wr(0, 47, '1);
      do_rd(4, "R4 write beside read dropped");

      // R8: back-to-back writes
      if (!k_next) @(negedge clk);
      wr_req = 1'b1; addr = AW'(2);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         wr_req = (k == 4);
         if (k == 4) addr = AW'(3);
         if (k >= 2 && k <= 5) put_beat(2, k - 2, 50, '1);
         if (k >= 6 && k <= 9) put_beat(3, k - 6, 51, '1);
      end
      bw = '0;

      // R8: back-to-back reads straight after, second block still buffered
      if (!k_next) @(negedge clk);
      rd_req = 1'b1; addr = AW'(2);
      for (int k = 1; k <= 12; k++) begin
         @(negedge clk);
         rd_req = (k == 4);
         if (k == 4) addr = AW'(3);
         if (k >= 4 && k <= 11) begin
            chk("R8 dq_oe gapless", DW'(dq_oe), DW'(1));
            chk("R8 streamed data", dq_out,
                (k <= 7) ? model[2*4 + k - 4] : model[3*4 + k - 8]);
         end else begin
            chk("R8 dq_oe idle", DW'(dq_oe), DW'(0));
         end
      end
      rd_req = 1'b0;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule